// File: doc/BRIEF.md
# Triggered Parallel Sample Capture

This block records a narrow group of parallel logic inputs at the rising edges of an external sample clock. Software first arms it. The first rising edge on the trigger input then starts a capture. The block collects a programmed number of samples, packs them into fixed-width words and returns to idle by itself. A reader takes each packed word through a full flag and an acknowledge. An overrun flag and a one-cycle done pulse complete the reader's view.

Two chained counters control a capture. The length counter is loaded on the trigger and counts every edge of the sample clock, both rising and falling, until the capture ends. The lane counter depends on the length counter. It is cleared on the trigger and tracks where the next sample goes inside the current word, and it decides when that word is moved to the output register. The sample clock, trigger and data pins arrive asynchronously and pass through one common two-stage synchronizer, so a sample and the clock edge that qualifies it stay aligned.

Top module: `trig_capture`

## Requirements
- R1: After reset, rx_full, rx_err and done are low and the block is idle: a trigger edge does not start a capture until arm has been pulsed.
- R2: Once armed, a rising edge on trig_in starts a capture. When the capture ends, the block returns to idle, and a later trigger edge produces no word and no done pulse.
- R3: A capture of N samples (1 to MAX_SAMPLES) runs for 2N sample-clock edges counted from the trigger, with the sample clock low at the trigger. The samples are taken at the N rising edges. done pulses high for exactly one cycle when the last edge is seen.
- R4: The width code w on wsel means that w+1 pins are used. The lane width is 4 bits for w of 0 to 3, 8 bits for 4 to 7, 16 bits for 8 to 15 and 32 bits above that.
- R5: Inside each lane, bit positions w+1 and above are filled with zero, whatever the unused pins carry.
- R6: Samples are packed with the earliest sample in bits [L-1:0] of the word, where L is the lane width, and each later sample goes into the next lane up. A word is emitted once WORD_W/L samples have been collected.
- R7: If the capture ends with a partly filled word, that word is emitted, with zero in the lanes that were not filled.
- R8: Each emitted word appears on rx_word and sets rx_full. A one-cycle pulse on rd_ack clears rx_full.
- R9: If a word is emitted while rx_full is still set and no rd_ack is present in that cycle, rx_err is set and the newer word replaces the older one. err_clr clears rx_err and leaves rx_full unchanged.
- R10: Trigger edges that arrive during a running capture are ignored, and n_samples and wsel are latched at the trigger. Changing them, or re-triggering, during a capture does not change the word count, the word contents or the single done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle pulse that arms the block for the next trigger |
| trig_in | input | 1 | Asynchronous trigger; a rising edge starts a capture when armed |
| sclk_in | input | 1 | Asynchronous sample clock |
| din | input | PINS | Asynchronous parallel data pins |
| n_samples | input | CNT_W | Number of samples per capture, latched at the trigger |
| wsel | input | WSEL_W | Width code: number of pins used minus one |
| rd_ack | input | 1 | Reader acknowledge, clears rx_full |
| err_clr | input | 1 | Clears rx_err |
| rx_word | output | WORD_W | Most recent packed word |
| rx_full | output | 1 | A word is waiting to be read |
| rx_err | output | 1 | Overrun: a word was replaced before it was read |
| done | output | 1 | One-cycle pulse at the end of a capture |

## Verification
The hardest conditions to reach are those inside a capture: a second trigger edge and a width change while the counters are running, and a word that completes while the previous one is still unread. The driver task produces the sample clock itself, so it can drop and raise the trigger and change wsel at chosen sample indices during a capture. In a separate run the monitor is switched to a mode that never acknowledges, which forces the second word of a two-word capture onto a full register. A capture whose sample count is not a multiple of the word's lane count exercises the flush of a partly filled word, and pulses after the block has returned to idle show that it ignores a trigger it was not armed for.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } cap_state_t;

  // lane width in bits for a given width code (pins used minus one)
  function automatic int unsigned lane_bits(input int unsigned code);
    if (code < 4)       return 4;
    else if (code < 8)  return 8;
    else if (code < 16) return 16;
    else                return 32;
  endfunction

endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q_out  <= '0;
    end else begin
      stage1 <= d_in;
      q_out  <= stage1;
    end
  end

endmodule

// File: rtl/tcap_len_ctr.sv
module tcap_len_ctr
  import tcap_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             trig_rise,
  input  logic             sclk_edge,
  input  logic [CNT_W-1:0] n_samples,
  output logic             start,
  output logic             running,
  output logic             last,
  output logic             done
);

  cap_state_t       state;
  logic [CNT_W:0]   remain;

  assign start   = (state == ST_ARMED) && trig_rise;
  assign running = (state == ST_RUN);
  assign last    = running && sclk_edge && (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      remain <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE:  if (arm) state <= ST_ARMED;
        ST_ARMED: if (trig_rise) begin
          state  <= ST_RUN;
          remain <= {n_samples, 1'b0} - 1'b1;
        end
        ST_RUN: if (sclk_edge) begin
          if (remain == '0) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            remain <= remain - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  remain_down_chk: assert property (@(posedge clk) disable iff (rst)
    (running && $past(running)) |-> (remain <= $past(remain)));

  // R2
  idle_no_run_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |=> (state != ST_RUN));

  // R3
  done_from_run_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(running));

endmodule

// File: rtl/tcap_packer.sv
module tcap_packer
  import tcap_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int WORD_W = 32,
  parameter int WSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              sample_en,
  input  logic              last,
  input  logic [WSEL_W-1:0] wsel,
  input  logic [PINS-1:0]   din,
  output logic              word_valid,
  output logic [WORD_W-1:0] word
);

  localparam int IDX_W = $clog2(WORD_W / 4) + 1;

  logic [5:0]        lane_q, lane_n;
  logic [IDX_W-1:0]  spw_q, spw_n, idx;
  logic [WORD_W-1:0] mask_q, mask_n, acc, ext, merged;
  logic [7:0]        shamt;

  always_comb begin
    lane_n = 6'(lane_bits(int'(wsel)));
    case (lane_n)
      6'd4:    spw_n = IDX_W'(WORD_W / 4);
      6'd8:    spw_n = IDX_W'(WORD_W / 8);
      6'd16:   spw_n = IDX_W'(WORD_W / 16);
      default: spw_n = IDX_W'(WORD_W / 32);
    endcase
    for (int i = 0; i < WORD_W; i++) mask_n[i] = (i <= int'(wsel));
  end

  assign ext    = WORD_W'(din) & mask_q;
  assign shamt  = 8'(idx) * {2'b00, lane_q};
  assign merged = acc | (ext << shamt);

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q     <= 6'd4;
      spw_q      <= IDX_W'(WORD_W / 4);
      mask_q     <= '0;
      acc        <= '0;
      idx        <= '0;
      word       <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (start) begin
        lane_q <= lane_n;
        spw_q  <= spw_n;
        mask_q <= mask_n;
        acc    <= '0;
        idx    <= '0;
      end else if (sample_en) begin
        if ((idx == spw_q - 1'b1) || last) begin
          word       <= merged;
          word_valid <= 1'b1;
          acc        <= '0;
          idx        <= '0;
        end else begin
          acc <= merged;
          idx <= idx + 1'b1;
        end
      end else if (last && (idx != '0)) begin
        word       <= acc;
        word_valid <= 1'b1;
        acc        <= '0;
        idx        <= '0;
      end
    end
  end

  // R6
  idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    idx < spw_q);

  // R6
  idx_restart_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> (idx == '0));

endmodule

// File: rtl/trig_capture.sv
module trig_capture #(
  parameter int PINS        = 8,
  parameter int WORD_W      = 32,
  parameter int MAX_SAMPLES = 4096,
  localparam int CNT_W      = $clog2(MAX_SAMPLES + 1),
  localparam int WSEL_W     = (PINS > 1) ? $clog2(PINS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              trig_in,
  input  logic              sclk_in,
  input  logic [PINS-1:0]   din,
  input  logic [CNT_W-1:0]  n_samples,
  input  logic [WSEL_W-1:0] wsel,
  input  logic              rd_ack,
  input  logic              err_clr,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_full,
  output logic              rx_err,
  output logic              done
);

  logic [PINS+1:0]   sync_q;
  logic [PINS-1:0]   s_din;
  logic              s_trig, s_sclk, trig_d, sclk_d;
  logic              trig_rise, sclk_rise, sclk_edge;
  logic              start, running, last;
  logic              word_valid;
  logic [WORD_W-1:0] word;

  tcap_sync #(.W(PINS + 2)) u_sync (
    .clk(clk), .rst(rst),
    .d_in({din, trig_in, sclk_in}),
    .q_out(sync_q)
  );

  assign {s_din, s_trig, s_sclk} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_d <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      trig_d <= s_trig;
      sclk_d <= s_sclk;
    end
  end

  assign trig_rise = s_trig & ~trig_d;
  assign sclk_rise = s_sclk & ~sclk_d;
  assign sclk_edge = s_sclk ^ sclk_d;

  tcap_len_ctr #(.CNT_W(CNT_W)) u_len (
    .clk(clk), .rst(rst), .arm(arm), .trig_rise(trig_rise),
    .sclk_edge(sclk_edge), .n_samples(n_samples),
    .start(start), .running(running), .last(last), .done(done)
  );

  tcap_packer #(.PINS(PINS), .WORD_W(WORD_W), .WSEL_W(WSEL_W)) u_pack (
    .clk(clk), .rst(rst), .start(start),
    .sample_en(running && sclk_rise), .last(last),
    .wsel(wsel), .din(s_din),
    .word_valid(word_valid), .word(word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_word <= '0;
      rx_full <= 1'b0;
      rx_err  <= 1'b0;
    end else begin
      if (err_clr) rx_err <= 1'b0;
      if (word_valid) begin
        rx_word <= word;
        rx_full <= 1'b1;
        if (rx_full && !rd_ack) rx_err <= 1'b1;
      end else if (rd_ack) begin
        rx_full <= 1'b0;
      end
    end
  end

  // R8
  full_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_full) |-> $past(word_valid));

  // R9
  err_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_err) |-> ($past(rx_full) && $past(word_valid)));

  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(word_valid) |-> $stable(rx_word));

endmodule

// File: tb/trig_capture_test.sv
module trig_capture_test;

  localparam int PINS = 8;
  localparam int WORD_W = 32;
  localparam int CNT_W = 13;
  localparam int WSEL_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm = 1'b0, trig_in = 1'b0, sclk_in = 1'b0, err_clr = 1'b0;
  logic rd_ack = 1'b0;
  logic [PINS-1:0] din = '0;
  logic [CNT_W-1:0] n_samples = '0;
  logic [WSEL_W-1:0] wsel = '0;
  logic [WORD_W-1:0] rx_word;
  logic rx_full, rx_err, done;

  int tests = 0, fails = 0, done_cnt = 0, mode = 0;
  bit finished = 0;
  logic [WORD_W-1:0] exp_q[$];
  logic [WORD_W-1:0] last_words[$];

  always #4 clk = ~clk;

  trig_capture #(.PINS(PINS), .WORD_W(WORD_W), .MAX_SAMPLES(4096)) uut (
    .clk(clk), .rst(rst), .arm(arm), .trig_in(trig_in), .sclk_in(sclk_in),
    .din(din), .n_samples(n_samples), .wsel(wsel), .rd_ack(rd_ack),
    .err_clr(err_clr), .rx_word(rx_word), .rx_full(rx_full),
    .rx_err(rx_err), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // monitor: mode 0 idle, 1 compare and ack, 2 ack without compare
  always @(negedge clk) begin
    if (!rst) begin
      if (done) done_cnt++;
      if (rd_ack) rd_ack = 1'b0;
      else if (rx_full && mode != 0) begin
        if (mode == 1) begin
          if (exp_q.size() == 0) check(0, "R2 unexpected word", rx_word, 0);
          else begin
            logic [WORD_W-1:0] e;
            e = exp_q.pop_front();
            check(rx_word == e, "R6 word", rx_word, e);
          end
        end
        rd_ack = 1'b1;
      end
    end
  end

  function automatic void pack(input int unsigned smp[], input int w, output logic [WORD_W-1:0] words[$]);
    int lane, spw, idx;
    logic [WORD_W-1:0] acc, m;
    lane = (w < 4) ? 4 : 8;
    spw = WORD_W / lane;
    m = (WORD_W'(1) << (w + 1)) - 1;
    acc = '0; idx = 0; words = {};
    foreach (smp[i]) begin
      acc |= (WORD_W'(smp[i]) & m) << (idx * lane);
      idx++;
      if (idx == spw) begin words.push_back(acc); acc = '0; idx = 0; end
    end
    if (idx != 0) words.push_back(acc);
  endfunction

  // driver: arms, triggers, clocks n samples; pushes expected words
  task automatic capture(input int n, input int w, input int seed, input bit push,
                         input bit disturb, input bit do_arm);
    int unsigned smp[];
    int d0;
    smp = new[n];
    foreach (smp[i]) smp[i] = (i * 37 + seed) & 8'hFF;
    pack(smp, w, last_words);
    if (push) foreach (last_words[i]) exp_q.push_back(last_words[i]);
    d0 = done_cnt;
    @(negedge clk);
    if (do_arm) begin arm = 1'b1; @(negedge clk); arm = 1'b0; end
    repeat (3) @(negedge clk);
    n_samples = CNT_W'(n); wsel = WSEL_W'(w);
    trig_in = 1'b1;
    repeat (10) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      din = PINS'(smp[i]);
      if (disturb && i == 1) trig_in = 1'b0;
      if (disturb && i == 2) begin trig_in = 1'b1; wsel = WSEL_W'(7 - w); n_samples = CNT_W'(2); end
      repeat (8) @(negedge clk);
      sclk_in = 1'b1;
      repeat (8) @(negedge clk);
      sclk_in = 1'b0;
    end
    repeat (12) @(negedge clk);
    trig_in = 1'b0;
    repeat (4) @(negedge clk);
    check(done_cnt - d0 == (do_arm ? 1 : 0), "R3 done pulses", done_cnt - d0, do_arm ? 1 : 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rx_full == 0, "R1 rx_full", rx_full, 0);
    check(rx_err == 0, "R1 rx_err", rx_err, 0);
    check(done == 0, "R1 done", done, 0);
    // R1: trigger with no arm after reset
    mode = 1;
    capture(8, 1, 3, 0, 0, 0);
    check(rx_full == 0, "R1 no capture unarmed", rx_full, 0);
    // R4 R5 R6: two pins in a 4-bit lane, 16 samples = 2 words
    capture(16, 1, 5, 1, 0, 1);
    check(exp_q.size() == 0, "R6 all words seen", exp_q.size(), 0);
    // R4 R5: six pins in an 8-bit lane
    capture(8, 5, 200, 1, 0, 1);
    check(exp_q.size() == 0, "R4 lane 8 words", exp_q.size(), 0);
    // R4: four pins, full nibble
    capture(8, 3, 11, 1, 0, 1);
    check(exp_q.size() == 0, "R4 lane 4 words", exp_q.size(), 0);
    // R7: partial final word, 10 samples of 4 bits
    capture(10, 2, 77, 1, 0, 1);
    check(exp_q.size() == 0, "R7 flushed word", exp_q.size(), 0);
    // R10: retrigger and width/count change during capture
    capture(12, 1, 9, 1, 1, 1);
    check(exp_q.size() == 0, "R10 words unchanged", exp_q.size(), 0);
    // R2: back in idle, trigger ignored
    capture(8, 3, 1, 0, 0, 0);
    check(rx_full == 0, "R2 idle after done", rx_full, 0);
    // R9: overrun with no reader
    mode = 0;
    capture(16, 3, 42, 0, 0, 1);
    check(rx_full == 1, "R8 full set", rx_full, 1);
    check(rx_err == 1, "R9 overrun flag", rx_err, 1);
    check(rx_word == last_words[1], "R9 newest kept", rx_word, last_words[1]);
    @(negedge clk); err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    @(negedge clk);
    check(rx_err == 0, "R9 err cleared", rx_err, 0);
    check(rx_full == 1, "R9 full kept", rx_full, 1);
    mode = 2;
    repeat (4) @(negedge clk);
    check(rx_full == 0, "R8 ack clears", rx_full, 0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule